// File: doc/BRIEF.md
# Row-Bypassing Unsigned Array Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and returns their full `2*WIDTH`-bit product. It has no clock and no state. The first partial product seeds a running sum. Each further multiplier bit owns one row of full adders, which folds that bit's shifted copy of the multiplicand into a carry-save pair of sum and carry vectors. A final ripple-carry row resolves the pair into the product.

A multiplier bit of zero adds nothing, so its row is skipped. Multiplexers pass the pending sum and carry vectors through that row unchanged, and the row contributes no carries of its own. AND gates force the row's adder inputs to zero so that its adders do not toggle. Operands with many zero bits in the multiplier therefore exercise fewer adders. The block is meant to sit where an operand is often sparse, and it is intended for widths of 4 and 16.

A small control module decodes the multiplier into one strobe pair per row. The datapath uses these strobes for operand gating and bypass selection.

Top module: `rowbypass_mult`

## Requirements
- R1: `product` equals the unsigned product `opA * opB` for every pair of operand values.
- R2: For each row r from 1 to WIDTH-1, the adder row is active exactly when bit r of `opB` is 1. The number of active rows equals the number of ones in `opB[WIDTH-1:1]`.
- R3: A bypassed row forwards the pending sum and carry vectors unchanged and generates no carry of its own. The product stays exact when zero multiplier bits sit between, before or after active rows, for example 1111 × 1001.
- R4: If either operand is zero, `product` is zero.
- R5: If `opB` is 1, `product` equals `opA` zero-extended. If `opA` is 1, `product` equals `opB` zero-extended.
- R6: When both operands are all ones, `product` equals (2^WIDTH − 1)², which for WIDTH=4 is 225.
- R7: If the top bit of `opB` is 0, bit 2*WIDTH−1 of `product` is 0.
- R8: The same RTL gives exact products when `WIDTH` is 16.
- R9: `product` follows a change on the operands with no clock edge. The block holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | Multiplicand, unsigned |
| opB | input | WIDTH | Multiplier, unsigned; its bits select active rows |
| product | output | 2*WIDTH | Unsigned product |

## Verification
The hardest case to reach from the ports is a carry that is still pending in the carry vector while one or more rows are bypassed, so that it has to travel past those rows to the final ripple row. Single-bit or all-ones multipliers never create this situation. The stimulus therefore uses multipliers with interior zero runs, such as 1001 and 0101, against all-ones and mixed multiplicands. It also sweeps every 4-bit pair, which covers every bypass pattern with every multiplicand. For 16 bits, random pairs and directed extreme and sparse patterns cover long bypass runs.

// File: rtl/rbm_pkg.sv
package rbm_pkg;

  // Per-row strobes from control to datapath
  typedef struct packed {
    logic addEn;   // row adders receive operands
    logic skipSel; // row output muxes select the forwarded vectors
  } rowStrobe_t;

  function automatic logic [1:0] fullAdd(input logic x, input logic y, input logic z);
    return {(x & y) | (x & z) | (y & z), x ^ y ^ z};
  endfunction

endpackage

// File: rtl/rbm_ctrl.sv
module rbm_ctrl #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]                   opB,
  output rbm_pkg::rowStrobe_t [WIDTH-1:0]    rowCtl
);

  for (genvar r = 0; r < WIDTH; r++) begin : g_row
    assign rowCtl[r].addEn   = opB[r];
    assign rowCtl[r].skipSel = ~opB[r];
  end

endmodule

// File: rtl/rbm_ripple.sv
module rbm_ripple #(
  parameter int PW = 8
) (
  input  logic [PW-1:0] addA,
  input  logic [PW-1:0] addB,
  output logic [PW-1:0] sum
);

  logic [PW-1:0] chain;
  assign chain[0] = 1'b0;

  for (genvar k = 0; k < PW; k++) begin : g_bit
    if (k < PW - 1) begin : g_full
      assign {chain[k+1], sum[k]} = rbm_pkg::fullAdd(addA[k], addB[k], chain[k]);
    end else begin : g_last
      assign sum[k] = addA[k] ^ addB[k] ^ chain[k];
    end
  end

endmodule

// File: rtl/rbm_datapath.sv
module rbm_datapath #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]                opA,
  input  rbm_pkg::rowStrobe_t [WIDTH-1:0] rowCtl,
  output logic [2*WIDTH-1:0]              product
);

  localparam int PW = 2 * WIDTH;

  // Running carry-save pair, indexed by absolute bit weight
  logic [PW-1:0] sumVec   [WIDTH];
  logic [PW-1:0] carryVec [WIDTH];

  // Row 0: first partial product seeds the sum, no adders
  assign sumVec[0]   = rowCtl[0].skipSel ? '0
                     : PW'(opA & {WIDTH{rowCtl[0].addEn}});
  assign carryVec[0] = '0;

  for (genvar r = 1; r < WIDTH; r++) begin : g_row
    logic [WIDTH-1:0] ppBits;
    logic [WIDTH-1:0] inSum;
    logic [WIDTH-1:0] inCar;
    logic [WIDTH-1:0] faSum;
    logic [WIDTH-1:0] faCar;
    logic [PW-1:0]    nxtSum;
    logic [PW-1:0]    nxtCar;

    // Operand isolation: every adder input is ANDed with the row enable
    assign ppBits = opA & {WIDTH{rowCtl[r].addEn}};
    assign inSum  = sumVec[r-1][r +: WIDTH]   & {WIDTH{rowCtl[r].addEn}};
    assign inCar  = carryVec[r-1][r +: WIDTH] & {WIDTH{rowCtl[r].addEn}};

    for (genvar c = 0; c < WIDTH; c++) begin : g_fa
      assign {faCar[c], faSum[c]} = rbm_pkg::fullAdd(inSum[c], inCar[c], ppBits[c]);
    end

    // Output multiplexers: bypass forwards the pending vectors untouched
    always_comb begin
      nxtSum = sumVec[r-1];
      nxtCar = carryVec[r-1];
      if (!rowCtl[r].skipSel) begin
        nxtSum[r +: WIDTH]     = faSum;
        nxtCar[r +: WIDTH]     = '0;
        nxtCar[r + 1 +: WIDTH] = faCar;
      end
    end

    assign sumVec[r]   = nxtSum;
    assign carryVec[r] = nxtCar;
  end

  rbm_ripple #(.PW(PW)) u_ripple (
    .addA (sumVec[WIDTH-1]),
    .addB (carryVec[WIDTH-1]),
    .sum  (product)
  );

endmodule

// File: rtl/rowbypass_mult.sv
module rowbypass_mult #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic [2*WIDTH-1:0] product
);

  rbm_pkg::rowStrobe_t [WIDTH-1:0] rowCtl;

  rbm_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .opB    (opB),
    .rowCtl (rowCtl)
  );

  rbm_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA     (opA),
    .rowCtl  (rowCtl),
    .product (product)
  );

endmodule

// File: rtl/rbm_checker.sv
module rbm_checker #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0]                opA,
  input logic [WIDTH-1:0]                opB,
  input logic [2*WIDTH-1:0]              product,
  input rbm_pkg::rowStrobe_t [WIDTH-1:0] rowCtl
);

  localparam int PW = 2 * WIDTH;

  logic [PW-1:0] extA;
  logic [PW-1:0] extB;
  assign extA = PW'(opA);
  assign extB = PW'(opB);

  always_comb begin
    int activeRows;
    activeRows = 0;
    for (int r = 1; r < WIDTH; r++) begin
      if (rowCtl[r].addEn && !rowCtl[r].skipSel) activeRows++;
    end

    assert_product_R1: assert (product == extA * extB)
      else $error("R1 product mismatch");
    assert_bypass_count_R2: assert (activeRows == $countones(opB[WIDTH-1:1]))
      else $error("R2 active row count mismatch");
    assert_zero_R4: assert (!(opA == '0 || opB == '0) || product == '0)
      else $error("R4 zero operand gives nonzero product");
    assert_unit_R5: assert ((opB != WIDTH'(1) || product == extA) &&
                            (opA != WIDTH'(1) || product == extB))
      else $error("R5 unit operand mismatch");
    assert_msb_R7: assert (opB[WIDTH-1] || !product[PW-1])
      else $error("R7 top product bit set");
  end

endmodule

bind rowbypass_mult rbm_checker #(.WIDTH(WIDTH)) u_rbmChk (
  .opA     (opA),
  .opB     (opB),
  .product (product),
  .rowCtl  (rowCtl)
);

// File: tb/rowbypass_mult_bench.sv
module rowbypass_mult_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // 4-bit instance
  logic [3:0] a4, b4;
  logic [7:0] p4;
  rowbypass_mult #(.WIDTH(4)) u_rowbypass_mult (.opA(a4), .opB(b4), .product(p4));

  // 16-bit instance
  logic [15:0] a16, b16;
  logic [31:0] p16;
  rowbypass_mult #(.WIDTH(16)) u_rowbypass_mult16 (.opA(a16), .opB(b16), .product(p16));

  // {opA, opB, expected product}
  localparam logic [15:0] VEC_TAB [8] = '{
    {4'hF, 4'h9, 8'h87},
    {4'hF, 4'hF, 8'hE1},
    {4'h1, 4'hF, 8'h0F},
    {4'h9, 4'h6, 8'h36},
    {4'h8, 4'h8, 8'h40},
    {4'hA, 4'h5, 8'h32},
    {4'h7, 4'h0, 8'h00},
    {4'hF, 4'h8, 8'h78}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply4(input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    a4 = a;
    b4 = b;
    #1;
  endtask

  initial begin
    a4 = '0; b4 = '0; a16 = '0; b16 = '0;
    repeat (3) @(negedge clk);
    // Reset state: zero operands give zero product (R4)
    check(p4 == 8'h00, "R4 reset state", 64'(p4), 64'h0);
    @(negedge clk);
    rst = 1'b0;

    // Vector table: sparse multipliers and mixed patterns (R1, R2, R3)
    for (int i = 0; i < 8; i++) begin
      apply4(VEC_TAB[i][15:12], VEC_TAB[i][11:8]);
      check(p4 == VEC_TAB[i][7:0], "R3 table vector", 64'(p4), 64'(VEC_TAB[i][7:0]));
    end

    // Exhaustive 4-bit sweep (R1, R2)
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        apply4(4'(a), 4'(b));
        check(p4 == 8'(a * b), "R1 exhaustive", 64'(p4), 64'(a * b));
      end
    end

    // Interior zero runs: row bypass patterns, R2 and R3
    apply4(4'hF, 4'h9);
    check(p4 == 8'd135, "R2 rows 1 and 2 bypassed", 64'(p4), 64'd135);
    apply4(4'hB, 4'h5);
    check(p4 == 8'd55, "R3 alternating bypass", 64'(p4), 64'd55);

    // Zero operands (R4)
    apply4(4'hD, 4'h0);
    check(p4 == 8'h00, "R4 zero multiplier", 64'(p4), 64'h0);
    apply4(4'h0, 4'hE);
    check(p4 == 8'h00, "R4 zero multiplicand", 64'(p4), 64'h0);

    // Unit operands (R5)
    for (int v = 0; v < 16; v++) begin
      apply4(4'(v), 4'h1);
      check(p4 == 8'(v), "R5 unit multiplier", 64'(p4), 64'(v));
      apply4(4'h1, 4'(v));
      check(p4 == 8'(v), "R5 unit multiplicand", 64'(p4), 64'(v));
    end

    // All ones (R6)
    apply4(4'hF, 4'hF);
    check(p4 == 8'd225, "R6 all ones", 64'(p4), 64'd225);

    // Top product bit clear when multiplier msb clear (R7)
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 8; b++) begin
        apply4(4'(a), 4'(b));
        check(p4[7] == 1'b0, "R7 top bit", 64'(p4[7]), 64'h0);
      end
    end

    // Combinational response without a clock edge (R9)
    @(posedge clk);
    #1;
    a4 = 4'h6; b4 = 4'h7;
    #1;
    check(p4 == 8'd42, "R9 no clock needed", 64'(p4), 64'd42);
    a4 = 4'h3;
    #1;
    check(p4 == 8'd21, "R9 follows change", 64'(p4), 64'd21);

    // 16-bit directed (R8)
    @(negedge clk);
    a16 = 16'hFFFF; b16 = 16'hFFFF; #1;
    check(p16 == 32'hFFFE0001, "R8 all ones 16", 64'(p16), 64'hFFFE0001);
    @(negedge clk);
    a16 = 16'h8000; b16 = 16'h8000; #1;
    check(p16 == 32'h40000000, "R8 msb squared", 64'(p16), 64'h40000000);
    @(negedge clk);
    a16 = 16'hFFFF; b16 = 16'h8001; #1;
    check(p16 == 32'h8000_7FFF, "R8 long bypass run", 64'(p16), 64'h80007FFF);

    // 16-bit random (R8)
    for (int i = 0; i < 600; i++) begin
      logic [31:0] expv;
      @(negedge clk);
      a16 = 16'($urandom);
      b16 = 16'($urandom);
      if (i % 3 == 0) b16 = b16 & 16'($urandom);
      #1;
      expv = 32'(a16) * 32'(b16);
      check(p16 == expv, "R8 random 16", 64'(p16), 64'(expv));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule